// File: doc/BRIEF.md
# Framed Serial Word Receiver

This block takes 16-bit command words from a three-wire serial link: a serial clock, a data line and an active-low frame sync. All three wires are sampled inside a faster system clock domain. Each one passes through a short synchronizer before its edges are detected. Data bits are taken on falling edges of the serial clock, most significant bit first.

A complete word is handed to a downstream register block on a parallel bus, together with a one-cycle valid strobe. A static mode input selects one of two framing schemes:

- **Controller framing.** Sync is held low for the whole word. Raising sync early throws the partial word away. The word is committed when sync rises.
- **Pulse framing.** A short low pulse on sync starts a word. The word ends by itself after sixteen clock edges, so words can follow each other with no gap.

A serial output repeats the incoming bit stream delayed by one word length. This lets several receivers share one link in a daisy chain. The output is forced low unless an enable input from the register block is set.

Top module: `sframe_rx`

## Requirements
- R1: While reset is held and immediately after it, `word_valid` is 0, `word_data` is 0 and `ser_dout` is 0.
- R2: A word is built from the data values present at 16 consecutive falling edges of `ser_clk`. The first bit taken becomes `word_data[15]` and the last becomes `word_data[0]`.
- R3: With `mode_mcu` = 1, a word is delivered on the rising edge of `ser_sync_n`, and only if exactly 16 falling edges of `ser_clk` occurred while `ser_sync_n` was low.
- R4: With `mode_mcu` = 1, if `ser_sync_n` rises after fewer than 16 falling edges, the partial word is discarded. No strobe is produced and `word_data` keeps its previous value.
- R5: With `mode_mcu` = 0, a falling edge of `ser_sync_n` while no word is in progress starts a word. The word is delivered right after its 16th falling edge of `ser_clk`, even if `ser_sync_n` has already returned high.
- R6: With `mode_mcu` = 0, back-to-back words are each delivered correctly. A back-to-back word is one whose sync pulse falls after the previous word's 16th edge, with no idle serial clocks in between.
- R7: With `mode_mcu` = 0, a falling edge of `ser_sync_n` during a word in progress is ignored, and the word is delivered unchanged.
- R8: `word_valid` is high for exactly one system clock per delivered word. `word_data` changes only in that cycle and holds its value until the next delivery.
- R9: With `chain_en` = 1, the value on `ser_dout` between falling edge k and edge k+1 of `ser_clk` equals the data bit taken at edge k-15 (0 before 16 edges have occurred). A downstream receiver sampling on edge k+1 therefore sees a delay of exactly 16 edges. The delay line shifts on every falling edge, whether or not a frame is open.
- R10: With `chain_en` = 0, `ser_dout` is 0. After `chain_en` rises, `ser_dout` shows the delayed stream at once, with no refill period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ser_clk | input | 1 | Serial clock (asynchronous, idles high) |
| ser_din | input | 1 | Serial data |
| ser_sync_n | input | 1 | Active-low frame sync |
| mode_mcu | input | 1 | Framing select: 1 = controller framing, 0 = pulse framing (static) |
| chain_en | input | 1 | Daisy-chain output enable from the register block |
| word_valid | output | 1 | One-cycle strobe, a word is delivered |
| word_data | output | 16 | Last delivered word |
| ser_dout | output | 1 | Input stream delayed by one word length |

## Verification
The bench builds the block with its default 16-bit word and a two-stage synchronizer. It runs the serial clock at one eighth of the system rate, so every synchronizer and edge-detect latency sits well inside one serial half period.

With these settings the bench can sweep every possible abort position in controller framing (1 to 15 bits). It also covers long back-to-back bursts in pulse framing, a stray sync pulse at each chosen mid-word position, and a bit-by-bit comparison of the chain output against a history of every bit sent, with enable toggled mid-stream.

// File: rtl/sframe_pkg.sv
// Shared constants and types for the framed serial word receiver.
package sframe_pkg;

    // Framing scheme selected by the static mode pin.
    typedef enum logic {
        FRAME_PULSE = 1'b0,
        FRAME_CTRL  = 1'b1
    } frame_mode_e;

    // Bit positions of the serial wires inside the synchronizer vector.
    localparam int unsigned IDX_DATA = 0;
    localparam int unsigned IDX_SYNC = 1;
    localparam int unsigned IDX_SCLK = 2;
    localparam int unsigned N_WIRES  = 3;

    // Idle levels: clock high, sync high (inactive), data low.
    localparam logic [N_WIRES-1:0] WIRE_IDLE = 3'b110;

endpackage

// File: rtl/sframe_sync.sv
// Multi-stage synchronizer for a vector of asynchronous wires.
// Assumes each wire is stable for several system clocks between changes;
// the stages only guard against metastability, not against bus skew.
module sframe_sync #(
    parameter int unsigned WIDTH   = 3,
    parameter int unsigned STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);

    logic [WIDTH-1:0] stage_q [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            // Stage s: take the wire (s==0) or the previous stage.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    stage_q[s] <= RST_VAL;
                end else if (s == 0) begin
                    stage_q[s] <= async_in;
                end else begin
                    stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
                end
            end
        end
    endgenerate

    assign sync_out = stage_q[STAGES-1];

endmodule

// File: rtl/sframe_ctrl.sv
// Frame control: edge detection on the synchronized serial clock and sync,
// bit counter, shift register, frame abort and word-complete strobe.
// Assumes the mode input is static while a word is in flight.
module sframe_ctrl
    import sframe_pkg::*;
#(
    parameter int unsigned WORD_W = 16,
    localparam int unsigned CNT_W = $clog2(WORD_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  frame_mode_e       mode,
    input  logic              sclk_s,
    input  logic              sync_s,
    input  logic              din_s,
    output logic              ser_fall,
    output logic [CNT_W-1:0]  bit_cnt,
    output logic              word_valid,
    output logic [WORD_W-1:0] word_data
);

    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(WORD_W);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(WORD_W - 1);

    logic              sclk_p, sync_p;
    logic              sync_rise, sync_fall;
    logic              busy;
    logic              pulse_start, take;
    logic [CNT_W-1:0]  cnt_base;
    logic [WORD_W-1:0] shreg;
    logic [WORD_W-1:0] shreg_next;

    // Previous levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_p <= 1'b1;
            sync_p <= 1'b1;
        end else begin
            sclk_p <= sclk_s;
            sync_p <= sync_s;
        end
    end

    // Edge flags and the decision whether this edge carries a data bit.
    always_comb begin
        ser_fall    = sclk_p & ~sclk_s;
        sync_rise   = ~sync_p & sync_s;
        sync_fall   = sync_p & ~sync_s;
        pulse_start = (mode == FRAME_PULSE) && sync_fall && !busy;
        cnt_base    = pulse_start ? '0 : bit_cnt;
        shreg_next  = {shreg[WORD_W-2:0], din_s};
        if (mode == FRAME_CTRL) begin
            take = ser_fall && !sync_s && (bit_cnt != CNT_FULL);
        end else begin
            take = ser_fall && (busy || pulse_start);
        end
    end

    // Counter, shift register and delivery for both framing schemes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy       <= 1'b0;
            bit_cnt    <= '0;
            shreg      <= '0;
            word_valid <= 1'b0;
            word_data  <= '0;
        end else begin
            word_valid <= 1'b0;
            if (mode == FRAME_CTRL) begin
                busy <= 1'b0;
                if (sync_rise) begin
                    if (bit_cnt == CNT_FULL) begin
                        word_valid <= 1'b1;
                        word_data  <= shreg;
                    end
                    bit_cnt <= '0;
                end else if (sync_s) begin
                    bit_cnt <= '0;
                end else if (take) begin
                    shreg   <= shreg_next;
                    bit_cnt <= bit_cnt + 1'b1;
                end
            end else begin
                if (take) begin
                    shreg <= shreg_next;
                    if (cnt_base == CNT_LAST) begin
                        word_valid <= 1'b1;
                        word_data  <= shreg_next;
                        busy       <= 1'b0;
                        bit_cnt    <= '0;
                    end else begin
                        busy    <= 1'b1;
                        bit_cnt <= cnt_base + 1'b1;
                    end
                end else if (pulse_start) begin
                    busy    <= 1'b1;
                    bit_cnt <= '0;
                end
            end
        end
    end

endmodule

// File: rtl/sframe_chain.sv
// Daisy-chain delay line: shifts the synchronized data on every serial
// clock falling edge and gates the oldest bit with the enable.
// Assumes the caller supplies a one-system-cycle falling-edge flag.
module sframe_chain #(
    parameter int unsigned DEPTH = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic shift_en,
    input  logic din_s,
    input  logic out_en,
    output logic dout
);

    logic [DEPTH-1:0] line_q;

    // Shift register advancing once per serial falling edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            line_q <= '0;
        end else if (shift_en) begin
            line_q <= {line_q[DEPTH-2:0], din_s};
        end
    end

    assign dout = out_en & line_q[DEPTH-1];

endmodule

// File: rtl/sframe_rx.sv
// Framed serial word receiver top: synchronizes the three serial wires,
// runs frame control and the daisy-chain delay line.
// Assumes mode_mcu is static and chain_en is synchronous to clk.
module sframe_rx
    import sframe_pkg::*;
#(
    parameter int unsigned WORD_W      = 16,
    parameter int unsigned SYNC_STAGES = 2,
    localparam int unsigned CNT_W      = $clog2(WORD_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ser_clk,
    input  logic              ser_din,
    input  logic              ser_sync_n,
    input  logic              mode_mcu,
    input  logic              chain_en,
    output logic              word_valid,
    output logic [WORD_W-1:0] word_data,
    output logic              ser_dout
);

    logic [N_WIRES-1:0] wires_raw, wires_s;
    logic               ser_fall;
    logic [CNT_W-1:0]   bit_cnt;
    frame_mode_e        mode;

    // Pack the serial wires into one vector for the synchronizer.
    always_comb begin
        wires_raw           = '0;
        wires_raw[IDX_SCLK] = ser_clk;
        wires_raw[IDX_SYNC] = ser_sync_n;
        wires_raw[IDX_DATA] = ser_din;
        mode                = mode_mcu ? FRAME_CTRL : FRAME_PULSE;
    end

    sframe_sync #(
        .WIDTH   (N_WIRES),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (WIRE_IDLE)
    ) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (wires_raw),
        .sync_out (wires_s)
    );

    sframe_ctrl #(
        .WORD_W (WORD_W)
    ) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode       (mode),
        .sclk_s     (wires_s[IDX_SCLK]),
        .sync_s     (wires_s[IDX_SYNC]),
        .din_s      (wires_s[IDX_DATA]),
        .ser_fall   (ser_fall),
        .bit_cnt    (bit_cnt),
        .word_valid (word_valid),
        .word_data  (word_data)
    );

    sframe_chain #(
        .DEPTH (WORD_W)
    ) u_chain (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (ser_fall),
        .din_s    (wires_s[IDX_DATA]),
        .out_en   (chain_en),
        .dout     (ser_dout)
    );

endmodule

// File: rtl/sframe_rx_chk.sv
// Assertion checker for sframe_rx, attached by bind below.
module sframe_rx_chk #(
    parameter int unsigned WORD_W = 16,
    localparam int unsigned CNT_W = $clog2(WORD_W + 1)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mode_mcu,
    input logic              chain_en,
    input logic              word_valid,
    input logic [WORD_W-1:0] word_data,
    input logic              ser_dout,
    input logic [CNT_W-1:0]  bit_cnt,
    input logic              clk_fall
);

    // R8
    valid_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        word_valid |=> !word_valid);

    // R8
    data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !word_valid |-> $stable(word_data));

    // R3
    ctrl_full_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_mcu && word_valid) |-> ($past(bit_cnt) == CNT_W'(WORD_W)));

    // R5
    pulse_last_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_mcu && word_valid) |-> ($past(clk_fall) && $past(bit_cnt) == CNT_W'(WORD_W - 1)));

    // R2
    cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bit_cnt <= CNT_W'(WORD_W));

    // R10
    chain_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !chain_en |-> !ser_dout);

endmodule

bind sframe_rx sframe_rx_chk #(.WORD_W(WORD_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode_mcu   (mode_mcu),
    .chain_en   (chain_en),
    .word_valid (word_valid),
    .word_data  (word_data),
    .ser_dout   (ser_dout),
    .bit_cnt    (bit_cnt),
    .clk_fall   (ser_fall)
);

// File: tb/sframe_rx_test.sv
// Self-checking bench for sframe_rx with sweeps over both framing schemes.
module sframe_rx_test;

    localparam int H = 4;  // system clocks per serial half period

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ser_clk = 1'b1;
    logic        ser_din = 1'b0;
    logic        ser_sync_n = 1'b1;
    logic        mode_mcu = 1'b1;
    logic        chain_en = 1'b0;
    logic        word_valid;
    logic [15:0] word_data;
    logic        ser_dout;

    int          n_chk = 0;
    int          n_fail = 0;
    int          v_count = 0;
    int          width_err = 0;
    logic [15:0] v_data = '0;
    logic        v_prev = 1'b0;
    int          n_fall = 0;
    bit          hist [8192];
    bit          done = 1'b0;

    always #10 clk = ~clk;  // 50 MHz

    sframe_rx uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .ser_clk    (ser_clk),
        .ser_din    (ser_din),
        .ser_sync_n (ser_sync_n),
        .mode_mcu   (mode_mcu),
        .chain_en   (chain_en),
        .word_valid (word_valid),
        .word_data  (word_data),
        .ser_dout   (ser_dout)
    );

    // Strobe monitor: counts deliveries and catches strobes wider than one cycle.
    always @(negedge clk) begin
        if (rst_n && word_valid) begin
            v_count = v_count + 1;
            v_data  = word_data;
            if (v_prev) width_err = width_err + 1;
        end
        v_prev = rst_n && word_valid;
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic wait_sys(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [15:0] gen(input int i);
        return 16'((i * 40503 + 4660) ^ (i << 7));
    endfunction

    // R9/R10: expected chain output after the current number of edges.
    task automatic check_dout();
        bit e;
        e = (chain_en && n_fall >= 16) ? hist[n_fall - 16] : 1'b0;
        check(ser_dout == e, chain_en ? "R9 chain delay" : "R10 chain gated low",
              int'(ser_dout), int'(e));
    endtask

    // One serial bit: data set while clock high, taken at the falling edge.
    task automatic send_bit(input bit b);
        ser_din = b;
        ser_clk = 1'b1;
        wait_sys(H);
        ser_clk = 1'b0;
        hist[n_fall] = b;
        n_fall++;
        wait_sys(H);
        #1 check_dout();
    endtask

    // Controller framing: sync held low for nbits bits, then raised.
    task automatic ctrl_frame(input logic [15:0] w, input int nbits);
        int          c0;
        logic [15:0] d0;
        c0 = v_count;
        d0 = v_data;
        ser_sync_n = 1'b0;
        wait_sys(H);
        for (int b = 15; b > 15 - nbits; b--) send_bit(w[b]);
        ser_sync_n = 1'b1;
        wait_sys(3 * H);
        #1;
        if (nbits == 16) begin
            check(v_count == c0 + 1, "R3 commit count", v_count, c0 + 1);
            check(v_data == w, "R2 R3 word value", int'(v_data), int'(w));
        end else begin
            check(v_count == c0, "R4 abort no strobe", v_count, c0);
            check(word_data == d0, "R4 data kept", int'(word_data), int'(d0));
        end
        ser_clk = 1'b1;
        wait_sys(H);
    endtask

    // Pulse framing burst of n words with no idle clocks; optional stray
    // sync pulse at bit position stray_at (-1 for none).
    task automatic pulse_burst(input int seed, input int n, input int stray_at);
        int          c0;
        logic [15:0] w;
        ser_sync_n = 1'b0;
        wait_sys(H);
        for (int k = 0; k < n; k++) begin
            w  = gen(seed + k);
            c0 = v_count;
            for (int b = 15; b >= 0; b--) begin
                send_bit(w[b]);
                if (b == 15) ser_sync_n = 1'b1;
                if (b == stray_at) begin
                    ser_sync_n = 1'b0;
                    wait_sys(H);
                    ser_sync_n = 1'b1;
                end
            end
            if (k < n - 1) ser_sync_n = 1'b0;
            check(v_count == c0 + 1, (stray_at >= 0) ? "R7 stray sync count" : "R5 R6 pulse count",
                  v_count, c0 + 1);
            check(v_data == w, (stray_at >= 0) ? "R7 stray sync value" : "R6 back-to-back value",
                  int'(v_data), int'(w));
        end
        ser_clk = 1'b1;
        wait_sys(2 * H);
    endtask

    initial begin
        wait_sys(5);
        #1;
        check(word_valid == 1'b0, "R1 reset valid", int'(word_valid), 0);
        check(word_data == 16'h0, "R1 reset data", int'(word_data), 0);
        check(ser_dout == 1'b0, "R1 reset dout", int'(ser_dout), 0);
        rst_n = 1'b1;
        wait_sys(2);
        #1;
        check(word_valid == 1'b0 && word_data == 16'h0, "R1 after reset", int'(word_data), 0);

        // Controller framing: fixed patterns, then every abort length.
        mode_mcu = 1'b1;
        ctrl_frame(16'hFFFF, 16);
        ctrl_frame(16'h0000, 16);
        ctrl_frame(16'h8001, 16);
        for (int i = 0; i < 15; i++) begin
            ctrl_frame(gen(100 + i), i + 1);
            ctrl_frame(gen(200 + i), 16);
        end
        chain_en = 1'b1;  // R10: enabled mid-stream, must be valid at once
        wait_sys(1);
        #1 check_dout();
        for (int i = 0; i < 6; i++) ctrl_frame(gen(300 + i), 16);

        // Pulse framing: long burst, then stray sync pulses mid-word.
        mode_mcu = 1'b0;
        pulse_burst(400, 20, -1);
        chain_en = 1'b0;
        wait_sys(1);
        #1 check_dout();
        pulse_burst(500, 4, 8);
        chain_en = 1'b1;
        wait_sys(1);
        #1 check_dout();
        pulse_burst(600, 4, 1);
        pulse_burst(700, 3, 14);

        check(width_err == 0, "R8 strobe width", width_err, 0);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule